// File: doc/BRIEF.md
# Parallel-Load Shift Serializer

This block turns an N-bit parallel word into a serial bit stream on one output, N being a parameter. A slow clock, which is the fast clock divided by N and edge-aligned to it, captures the parallel word into a row of holding registers. A chain of N fast-clock registers then presents the word on `dout`, one bit per fast cycle, least significant bit first.

The choice between loading and shifting is made by a free-running one-hot ring of N flops clocked on the falling edge of the fast clock. The hot bit, when it sits in the top position, is the load strobe. While the strobe is high, every stage of the fast chain takes its held bit. Otherwise each stage takes the output of the stage before it. Because the ring advances on the falling edge, the strobe is steady around the rising edge that uses it.

The ring is seeded by a reset whose form is picked at build time. In one form, an active-high asynchronous input passes through a two-flop synchronizer on the falling edge of the fast clock. In the other form, an active-low input that is already synchronous drives the ring reset directly. Clock generation and clock buffering are left to the surrounding logic.

Top module: `pshift_serializer`

## Requirements
- R1: On each rising edge of `clkDiv` the holding registers capture `din`. The word used at a load edge is the one captured by the latest `clkDiv` edge strictly before that fast edge. A capture in the same instant as the load edge is used at the next load.
- R2: After a load edge, `dout` carries `din[0]` of the loaded word for one fast cycle, then `din[1]`, and so on up to `din[N-1]`.
- R3: Outside reset the ring holds exactly one hot bit. It advances one position on every falling edge of `clk`, so the load strobe is high for exactly one rising edge in every N.
- R4: While the ring reset is active, the load strobe stays high, so every rising edge of `clk` reloads the chain and `dout` holds bit 0 of the held word.
- R5: With `RST_ASYNC`=1, `rstRaw` is active-high and forces the ring into its seed state at once. After `rstRaw` falls, the ring first advances on the third falling edge of `clk`.
- R6: With `RST_ASYNC`=0, `rstRaw` is active-low and drives the ring reset directly. After `rstRaw` rises, the ring advances on the first falling edge of `clk`.
- R7: The ring seed has the top position (bit N-1, the load position) hot and all other positions cold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast bit clock |
| clkDiv | input | 1 | Fast clock divided by NUM_BITS, rising edge aligned to a rising edge of `clk` |
| rstRaw | input | 1 | Ring reset: active-high asynchronous when RST_ASYNC=1, active-low synchronous when RST_ASYNC=0 |
| din | input | NUM_BITS | Parallel word |
| dout | output | 1 | Serial stream, bit 0 first |

## Verification
Two events can fall on the same rising edge of the fast clock: the holding registers capturing a new word and the fast chain loading from them. The chain must take the word captured one divided period earlier. The bench releases reset at a different fast-cycle offset from the divided clock on each pass, so the ring phase sweeps through every alignment, the coinciding one included. A behavioural model, built from word queues and counters, predicts every `dout` bit across these offsets. Mismatches on coinciding edges are reported under their own tag.

// File: rtl/ser_pkg.sv
package ser_pkg;
  // Strobe pair from control to datapath: load and its complement,
  // driving the two legs of each stage selector.
  typedef struct packed {
    logic load;
    logic hold;
  } serStrobe_t;
endpackage

// File: rtl/ser_ctrl.sv
module ser_ctrl
  import ser_pkg::*;
#(
  parameter int NUM_BITS  = 8,
  parameter bit RST_ASYNC = 1'b1
) (
  input  logic                clk,
  input  logic                rstRaw,
  output logic                ringRst,
  output logic [NUM_BITS-1:0] ringPtr,
  output serStrobe_t          strobes
);
  localparam int TOP = NUM_BITS - 1;
  localparam logic [NUM_BITS-1:0] RING_SEED = {1'b1, {TOP{1'b0}}};

  logic [NUM_BITS-1:0] ringQ;

  generate
    if (RST_ASYNC) begin : gAsyncRst
      logic [1:0] syncQ;
      always_ff @(negedge clk or posedge rstRaw) begin
        if (rstRaw) syncQ <= 2'b00;
        else        syncQ <= {syncQ[0], 1'b1};
      end
      assign ringRst = ~syncQ[1];
    end else begin : gSyncRst
      assign ringRst = ~rstRaw;
    end
  endgenerate

  // One-hot pointer ring on the falling edge; the top bit wraps to bit 0.
  always_ff @(negedge clk or posedge ringRst) begin
    if (ringRst) ringQ <= RING_SEED;
    else         ringQ <= {ringQ[TOP-1:0], ringQ[TOP]};
  end

  assign ringPtr = ringQ;

  always_comb begin
    strobes.load = ringQ[TOP];
    strobes.hold = ~ringQ[TOP];
  end
endmodule

// File: rtl/ser_datapath.sv
module ser_datapath
  import ser_pkg::*;
#(
  parameter int NUM_BITS = 8
) (
  input  logic                clk,
  input  logic                clkDiv,
  input  logic [NUM_BITS-1:0] din,
  input  serStrobe_t          strobes,
  output logic                dout
);
  localparam int TOP = NUM_BITS - 1;

  logic [NUM_BITS-1:0] dinRev;
  logic [NUM_BITS-1:0] heldQ;
  logic [NUM_BITS-1:0] stageD;
  logic [NUM_BITS-1:0] stageQ;

  // Parallel bit k lands in holding slot TOP-k.
  generate
    for (genvar k = 0; k < NUM_BITS; k++) begin : gRev
      assign dinRev[TOP-k] = din[k];
    end
  endgenerate

  always_ff @(posedge clkDiv) begin
    heldQ <= dinRev;
  end

  // Stage 0 has no predecessor and always takes its held bit;
  // the others choose through an AND-OR pair driven by the strobes.
  generate
    for (genvar j = 0; j < NUM_BITS; j++) begin : gStage
      if (j == 0) begin : gHead
        assign stageD[j] = heldQ[j];
      end else begin : gBody
        assign stageD[j] = (heldQ[j] & strobes.load) | (stageQ[j-1] & strobes.hold);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    stageQ <= stageD;
  end

  assign dout = stageQ[TOP];
endmodule

// File: rtl/pshift_serializer.sv
module pshift_serializer
  import ser_pkg::*;
#(
  parameter int NUM_BITS  = 8,
  parameter bit RST_ASYNC = 1'b1
) (
  input  logic                clk,
  input  logic                clkDiv,
  input  logic                rstRaw,
  input  logic [NUM_BITS-1:0] din,
  output logic                dout
);
  logic                ringRst;
  logic [NUM_BITS-1:0] ringPtr;
  serStrobe_t          strobes;

  ser_ctrl #(.NUM_BITS(NUM_BITS), .RST_ASYNC(RST_ASYNC)) uCtrl (
    .clk     (clk),
    .rstRaw  (rstRaw),
    .ringRst (ringRst),
    .ringPtr (ringPtr),
    .strobes (strobes)
  );

  ser_datapath #(.NUM_BITS(NUM_BITS)) uPath (
    .clk     (clk),
    .clkDiv  (clkDiv),
    .din     (din),
    .strobes (strobes),
    .dout    (dout)
  );
endmodule

// File: rtl/ser_checker.sv
module ser_checker
  import ser_pkg::*;
#(
  parameter int NUM_BITS  = 8,
  parameter bit RST_ASYNC = 1'b1
) (
  input logic                clk,
  input logic                rstRaw,
  input logic                ringRst,
  input logic [NUM_BITS-1:0] ringPtr,
  input serStrobe_t          strobes
);
  int sinceLoad;

  always_ff @(posedge clk) begin
    if (ringRst || strobes.load) sinceLoad <= 0;
    else                         sinceLoad <= sinceLoad + 1;
  end

  // R3
  ring_onehot_chk: assert property (@(posedge clk) disable iff (ringRst)
    $countones(ringPtr) == 1);

  // R3
  load_single_chk: assert property (@(posedge clk) disable iff (ringRst)
    strobes.load |=> !strobes.load);

  // R3
  load_period_chk: assert property (@(posedge clk) disable iff (ringRst)
    (strobes.load && !$past(strobes.load)) |-> (sinceLoad == NUM_BITS - 1));

  // R4 R7
  always @(posedge clk) begin
    if (ringRst) begin
      reset_seed_load_chk: assert (strobes.load && ringPtr[NUM_BITS-1]);
    end
  end

  generate
    if (RST_ASYNC) begin : gAsyncChk
      // R5
      always @(posedge clk) begin
        if (rstRaw) begin
          async_hold_chk: assert (ringRst);
        end
      end
    end else begin : gSyncChk
      // R6
      always @(posedge clk) begin
        if (!rstRaw) begin
          sync_hold_chk: assert (ringRst);
        end
      end
    end
  endgenerate
endmodule

bind pshift_serializer ser_checker #(.NUM_BITS(NUM_BITS), .RST_ASYNC(RST_ASYNC)) uChk (
  .clk     (clk),
  .rstRaw  (rstRaw),
  .ringRst (ringRst),
  .ringPtr (ringPtr),
  .strobes (strobes)
);

// File: tb/ser_harness.sv
module ser_harness #(
  parameter int N     = 4,
  parameter bit ASYNC = 1'b0
) (
  input  logic clk,
  output int   checks,
  output int   fails,
  output logic done
);
  logic         clkDiv = 1'b0;
  int           divCnt = 0;
  logic         rstRaw = ASYNC ? 1'b0 : 1'b1;
  logic [N-1:0] din = '0;
  logic         dout;

  pshift_serializer #(.NUM_BITS(N), .RST_ASYNC(ASYNC)) u0 (
    .clk    (clk),
    .clkDiv (clkDiv),
    .rstRaw (rstRaw),
    .din    (din),
    .dout   (dout)
  );

  // Divided clock from the same source, rising with clk when divCnt wraps.
  always @(posedge clk) begin
    clkDiv <= (divCnt == N - 1) || (divCnt < N / 2 - 1);
    divCnt <= (divCnt == N - 1) ? 0 : divCnt + 1;
  end

  // Behavioural reference: pointer position, release age, word in flight.
  int           mPtr = N - 1;
  int           syncCnt = 0;
  int           relAge = 0;
  int           idx = 0;
  bit           lastRst = 1'b1;
  bit           heldValid = 1'b0;
  bit           curValid = 1'b0;
  bit           cmpValid = 1'b0;
  bit           expBit = 1'b0;
  bit           coincide = 1'b0;
  logic [N-1:0] mHeld = '0;
  logic [N-1:0] curWord = '0;
  string        tag = "R2";

  initial begin
    checks = 0;
    fails = 0;
    done = 1'b0;
  end

  always @(posedge clk) begin
    bit capture;
    capture = (divCnt == N - 1);
    if (mPtr == N - 1) begin
      curWord  = mHeld;     // word from the previous capture (R1)
      curValid = heldValid;
      idx      = 0;
      coincide = capture;
    end else begin
      idx = idx + 1;
    end
    cmpValid = curValid && (idx < N);
    expBit   = curValid ? curWord[idx] : 1'b0;
    if (lastRst)           tag = "R4 R7";
    else if (coincide)     tag = "R1";
    else if (relAge < 2*N) tag = ASYNC ? "R5" : "R6";
    else                   tag = "R2 R3";
    if (capture) begin
      mHeld     = din;
      heldValid = 1'b1;
    end
  end

  always @(negedge clk) begin
    bit rstNow;
    if (cmpValid) begin
      checks = checks + 1;
      if (dout !== expBit) begin
        fails = fails + 1;
        $display("FAIL %s N=%0d t=%0t dout=%0b expected=%0b", tag, N, $time, dout, expBit);
      end
    end
    rstNow = ASYNC ? (rstRaw || syncCnt < 2) : !rstRaw;
    if (rstNow) mPtr = N - 1;
    else        mPtr = (mPtr + 1) % N;
    if (ASYNC) begin
      if (rstRaw)           syncCnt = 0;
      else if (syncCnt < 2) syncCnt = syncCnt + 1;
    end
    if (rstNow) relAge = 0;
    else        relAge = relAge + 1;
    lastRst = rstNow;
  end

  // Word source: fixed corner patterns first, then random words.
  initial begin
    int w;
    w = 0;
    while (!done) begin
      logic [31:0] r;
      logic [N-1:0] nxt;
      @(posedge clkDiv);
      #3;
      r = $urandom;
      case (w)
        0: nxt = {{(N-1){1'b0}}, 1'b1};
        1: nxt = {1'b1, {(N-1){1'b0}}};
        2: nxt = '1;
        3: nxt = '0;
        4: for (int b = 0; b < N; b++) nxt[b] = b[0];
        default: nxt = r[N-1:0];
      endcase
      din = nxt;
      w = w + 1;
    end
  end

  // Reset passes with a sweeping release offset against clkDiv (R1, R5, R6).
  initial begin
    #1 rstRaw = ASYNC ? 1'b1 : 1'b0;
    for (int ph = 0; ph <= N; ph++) begin
      repeat (2 + ph) @(posedge clk);
      #3 rstRaw = ASYNC ? 1'b0 : 1'b1;
      repeat (6 * N) @(posedge clk);
      #3 rstRaw = ASYNC ? 1'b1 : 1'b0;
    end
    repeat (3) @(posedge clk);
    done = 1'b1;
  end
endmodule

// File: tb/sim_pshift_serializer.sv
module sim_pshift_serializer;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  int   cA, fA, cB, fB;
  logic dA, dB;
  int   wdFail = 0;

  // Four-bit build with the direct synchronous reset (R6).
  ser_harness #(.N(4), .ASYNC(1'b0)) hA (.clk(clk), .checks(cA), .fails(fA), .done(dA));
  // Eight-bit build with the synchronized asynchronous reset (R5).
  ser_harness #(.N(8), .ASYNC(1'b1)) hB (.clk(clk), .checks(cB), .fails(fB), .done(dB));

  initial begin
    int cyc;
    cyc = 0;
    while (!(dA === 1'b1 && dB === 1'b1) && cyc < 20000) begin
      @(posedge clk);
      cyc = cyc + 1;
    end
    if (!(dA === 1'b1 && dB === 1'b1)) begin
      wdFail = 1;
      $display("FAIL watchdog: run did not complete, done=%0b%0b expected=11", dA, dB);
    end
    #1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cA + cB + wdFail, fA + fB + wdFail);
    $finish;
  end
endmodule